// File: doc/BRIEF.md
# Packed Lane Rearrangement Unit

This block reorders and narrows the lanes of two 64-bit packed operands, called the destination operand and the source operand. An opcode picks one of three kinds of operation. Narrowing packs convert wider elements to narrower ones and clamp them at the narrow type's limits instead of wrapping. Interleaves merge the low or the high halves of both operands lane by lane. A byte shuffle builds each result byte from a byte of the destination operand, selected by a control byte from the source operand.

The result is registered. It appears on the output one clock after the inputs are presented, and a new operation can be presented on every cycle. Inside a packed-integer execution pipeline, the block sits beside the arithmetic lanes and handles only data movement.

Top module: `packed_rearrange_unit`

## Requirements
- R1: While reset is asserted the result is zero. Otherwise the result equals the function of the opcode, operands and half select sampled at the previous rising clock edge.
- R2: Opcode encoding: 0 signed dword-to-word pack, 1 signed word-to-byte pack, 2 unsigned word-to-byte pack, 3 byte interleave, 4 word interleave, 5 dword interleave, 6 byte shuffle.
- R3: Signed dword-to-word pack treats each 32-bit element as signed. Values above 32767 become 0x7FFF and values below -32768 become 0x8000. Both destination elements go to result words 0 and 1 and both source elements go to words 2 and 3, each in its original order.
- R4: Signed word-to-byte pack treats each 16-bit element as signed. Values above 127 become 0x7F and values below -128 become 0x80. Destination words go to result bytes 0 to 3 and source words go to bytes 4 to 7.
- R5: Unsigned word-to-byte pack treats each 16-bit element as signed. Negative values become 0x00 and values above 255 become 0xFF. It uses the same placement as R4.
- R6: Byte interleave with half select 0 takes bytes 0 to 3 of each operand, and with half select 1 takes bytes 4 to 7. Result byte 2k holds the destination's k-th selected byte and byte 2k+1 holds the source's. With a zero source this zero-extends four bytes into words.
- R7: Word interleave applies the R6 rule to 16-bit elements: two words from each operand, the destination word in the lower position of each pair.
- R8: Dword interleave puts the selected destination dword in result bits 31:0 and the selected source dword in bits 63:32.
- R9: Byte shuffle: when bit 7 of source byte i is clear, result byte i is the destination byte indexed by bits 2:0 of source byte i. Bits 6:3 are ignored and an index may repeat.
- R10: Byte shuffle: result byte i is 0x00 whenever bit 7 of source byte i is set.
- R11: Opcode 7 yields a zero result.
- R12: The half select has no effect on packs and shuffles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code (R2) |
| hi_i | input | 1 | Half select for interleaves: 0 low, 1 high |
| dst_i | input | 64 | Destination operand |
| src_i | input | 64 | Source operand or shuffle control |
| res_o | output | 64 | Registered result |

## Verification
Uniformly random operands drive every opcode with both half-select values. Most random words lie outside the narrow range, so these runs mainly exercise the clamp on both sides, and they show whether lane placement is correct for interleaves and shuffles. Directed operands then sit exactly on each clamp boundary (for example 127, 128, -128, -129 and 255, 256), which separates an off-by-one clamp from a correct one. Shuffle control bytes with bits 6:3 set, repeated indices and bit 7 set separate index masking from zeroing. An interleave with a zero source confirms zero-extension.

// File: rtl/pru_pkg.sv
package pru_pkg;

    localparam int DATA_W = 64;

    typedef enum logic [2:0] {
        OP_PACK_DW_SS = 3'd0,
        OP_PACK_W_SS  = 3'd1,
        OP_PACK_W_US  = 3'd2,
        OP_ILV_B      = 3'd3,
        OP_ILV_W      = 3'd4,
        OP_ILV_D      = 3'd5,
        OP_SHUF_B     = 3'd6,
        OP_NONE       = 3'd7
    } pru_op_e;

    function automatic logic [15:0] sat_s16(input logic [31:0] v);
        if ($signed(v) > 32'sd32767)       return 16'h7FFF;
        else if ($signed(v) < -32'sd32768) return 16'h8000;
        else                               return v[15:0];
    endfunction

    function automatic logic [7:0] sat_s8(input logic [15:0] v);
        if ($signed(v) > 16'sd127)       return 8'h7F;
        else if ($signed(v) < -16'sd128) return 8'h80;
        else                             return v[7:0];
    endfunction

    function automatic logic [7:0] sat_u8(input logic [15:0] v);
        if (v[15])               return 8'h00;
        else if (v[14:8] != '0)  return 8'hFF;
        else                     return v[7:0];
    endfunction

endpackage

// File: rtl/pru_narrow.sv
module pru_narrow
    import pru_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [1:0]   mode_i,   // 0 dw->w signed, 1 w->b signed, 2 w->b unsigned
    input  logic [W-1:0] dst_i,
    input  logic [W-1:0] src_i,
    output logic [W-1:0] res_o
);
    localparam int HALF = W / 2;
    localparam int N_DW = W / 32;
    localparam int N_W  = W / 16;

    logic [W-1:0] dw_to_w;
    logic [W-1:0] w_to_bs;
    logic [W-1:0] w_to_bu;

    for (genvar i = 0; i < N_DW; i++) begin : g_dw
        assign dw_to_w[16*i +: 16]        = sat_s16(dst_i[32*i +: 32]);
        assign dw_to_w[HALF + 16*i +: 16] = sat_s16(src_i[32*i +: 32]);
    end

    for (genvar i = 0; i < N_W; i++) begin : g_w
        assign w_to_bs[8*i +: 8]        = sat_s8(dst_i[16*i +: 16]);
        assign w_to_bs[HALF + 8*i +: 8] = sat_s8(src_i[16*i +: 16]);
        assign w_to_bu[8*i +: 8]        = sat_u8(dst_i[16*i +: 16]);
        assign w_to_bu[HALF + 8*i +: 8] = sat_u8(src_i[16*i +: 16]);
    end

    always_comb begin
        case (mode_i)
            2'd0:    res_o = dw_to_w;
            2'd1:    res_o = w_to_bs;
            default: res_o = w_to_bu;
        endcase
    end
endmodule

// File: rtl/pru_interleave.sv
module pru_interleave
    import pru_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [1:0]   size_i,   // 0 byte, 1 word, 2 dword
    input  logic         hi_i,
    input  logic [W-1:0] dst_i,
    input  logic [W-1:0] src_i,
    output logic [W-1:0] res_o
);
    localparam int HALF = W / 2;
    localparam int N_B  = HALF / 8;
    localparam int N_W  = HALF / 16;

    logic [HALF-1:0] dh, sh;
    logic [W-1:0]    ilv_b, ilv_w, ilv_d;

    assign dh = hi_i ? dst_i[W-1:HALF] : dst_i[HALF-1:0];
    assign sh = hi_i ? src_i[W-1:HALF] : src_i[HALF-1:0];

    for (genvar k = 0; k < N_B; k++) begin : g_b
        assign ilv_b[16*k +: 16] = {sh[8*k +: 8], dh[8*k +: 8]};
    end
    for (genvar k = 0; k < N_W; k++) begin : g_w
        assign ilv_w[32*k +: 32] = {sh[16*k +: 16], dh[16*k +: 16]};
    end
    assign ilv_d = {sh, dh};

    always_comb begin
        case (size_i)
            2'd0:    res_o = ilv_b;
            2'd1:    res_o = ilv_w;
            default: res_o = ilv_d;
        endcase
    end
endmodule

// File: rtl/pru_shuffle.sv
module pru_shuffle
    import pru_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] dst_i,
    input  logic [W-1:0] src_i,
    output logic [W-1:0] res_o
);
    localparam int NB    = W / 8;
    localparam int IDX_W = $clog2(NB);

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [7:0]       ctl;
        logic [IDX_W-1:0] idx;
        assign ctl = src_i[8*i +: 8];
        assign idx = ctl[IDX_W-1:0];
        assign res_o[8*i +: 8] = ctl[7] ? 8'h00 : dst_i[8*idx +: 8];
    end
endmodule

// File: rtl/packed_rearrange_unit.sv
module packed_rearrange_unit
    import pru_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  op_i,
    input  logic        hi_i,
    input  logic [63:0] dst_i,
    input  logic [63:0] src_i,
    output logic [63:0] res_o
);
    typedef struct packed {
        logic [DATA_W-1:0] res;
    } state_t;

    state_t    st_d, st_q;
    pru_op_e   op;
    logic [DATA_W-1:0] narrow_res, ilv_res, shuf_res;
    logic [1:0] narrow_mode, ilv_size;

    assign op          = pru_op_e'(op_i);
    assign narrow_mode = op_i[1:0];
    assign ilv_size    = op_i[1:0] - 2'd3;

    pru_narrow #(.W(DATA_W)) i_narrow (
        .mode_i(narrow_mode), .dst_i(dst_i), .src_i(src_i), .res_o(narrow_res)
    );

    pru_interleave #(.W(DATA_W)) i_ilv (
        .size_i(ilv_size), .hi_i(hi_i), .dst_i(dst_i), .src_i(src_i), .res_o(ilv_res)
    );

    pru_shuffle #(.W(DATA_W)) i_shuf (
        .dst_i(dst_i), .src_i(src_i), .res_o(shuf_res)
    );

    always_comb begin
        st_d = st_q;
        case (op)
            OP_PACK_DW_SS, OP_PACK_W_SS, OP_PACK_W_US: st_d.res = narrow_res;
            OP_ILV_B, OP_ILV_W, OP_ILV_D:              st_d.res = ilv_res;
            OP_SHUF_B:                                 st_d.res = shuf_res;
            default:                                   st_d.res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o = st_q.res;

    // R1: reset drives the result to zero
    p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> res_o == 64'h0);

    // R3: large negative dword clamps to 0x8000 in word 0
    p_dw_clamp_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd0 && $signed(dst_i[31:0]) < -32'sd32768) |=> res_o[15:0] == 16'h8000);

    // R4: word above 127 clamps to 0x7F in byte 4
    p_ws_clamp_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1 && $signed(src_i[15:0]) > 16'sd127) |=> res_o[39:32] == 8'h7F);

    // R5: negative word clamps to zero in unsigned pack
    p_wu_neg_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2 && dst_i[15]) |=> res_o[7:0] == 8'h00);

    // R6: low byte interleave places source byte 0 at result byte 1
    p_ilv_b_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd3 && !hi_i) |=> res_o[15:8] == $past(src_i[7:0]));

    // R8: high dword interleave places destination high dword low
    p_ilv_d_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd5 && hi_i) |=> res_o[31:0] == $past(dst_i[63:32]));

    // R10: control byte with bit 7 set zeroes its lane
    p_shuf_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd6 && src_i[63]) |=> res_o[63:56] == 8'h00);

    // R11: unused opcode gives zero
    p_none_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd7) |=> res_o == 64'h0);
endmodule

// File: tb/test_packed_rearrange_unit.sv
module test_packed_rearrange_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = '0;
    logic        hi_i = 1'b0;
    logic [63:0] dst_i = '0;
    logic [63:0] src_i = '0;
    logic [63:0] res_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    packed_rearrange_unit i_packed_rearrange_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .hi_i(hi_i),
        .dst_i(dst_i), .src_i(src_i), .res_o(res_o)
    );

    function automatic logic [15:0] m_s16(logic [31:0] v);
        int signed x = $signed(v);
        if (x > 32767) return 16'h7FFF;
        if (x < -32768) return 16'h8000;
        return v[15:0];
    endfunction

    function automatic logic [7:0] m_s8(logic [15:0] v);
        int signed x = $signed(v);
        if (x > 127) return 8'h7F;
        if (x < -128) return 8'h80;
        return v[7:0];
    endfunction

    function automatic logic [7:0] m_u8(logic [15:0] v);
        int signed x = $signed(v);
        if (x < 0) return 8'h00;
        if (x > 255) return 8'hFF;
        return v[7:0];
    endfunction

    function automatic logic [63:0] model(logic [2:0] op, logic hi, logic [63:0] d, logic [63:0] s);
        logic [63:0] r = '0;
        int b = hi ? 32 : 0;
        case (op)
            3'd0: for (int i = 0; i < 2; i++) begin
                r[16*i +: 16]      = m_s16(d[32*i +: 32]);
                r[32 + 16*i +: 16] = m_s16(s[32*i +: 32]);
            end
            3'd1: for (int i = 0; i < 4; i++) begin
                r[8*i +: 8]      = m_s8(d[16*i +: 16]);
                r[32 + 8*i +: 8] = m_s8(s[16*i +: 16]);
            end
            3'd2: for (int i = 0; i < 4; i++) begin
                r[8*i +: 8]      = m_u8(d[16*i +: 16]);
                r[32 + 8*i +: 8] = m_u8(s[16*i +: 16]);
            end
            3'd3: for (int k = 0; k < 4; k++) begin
                r[16*k +: 8]     = d[b + 8*k +: 8];
                r[16*k + 8 +: 8] = s[b + 8*k +: 8];
            end
            3'd4: for (int k = 0; k < 2; k++) begin
                r[32*k +: 16]      = d[b + 16*k +: 16];
                r[32*k + 16 +: 16] = s[b + 16*k +: 16];
            end
            3'd5: begin
                r[31:0]  = d[b +: 32];
                r[63:32] = s[b +: 32];
            end
            3'd6: for (int i = 0; i < 8; i++) begin
                if (s[8*i + 7]) r[8*i +: 8] = 8'h00;
                else            r[8*i +: 8] = d[8 * int'(s[8*i +: 3]) +: 8];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(logic [2:0] op, logic hi);
        if (hi && (op < 3'd3 || op == 3'd6)) return "R12";
        case (op)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            3'd6: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run(logic [2:0] op, logic hi, logic [63:0] d, logic [63:0] s, string tag);
        @(negedge clk);
        op_i = op; hi_i = hi; dst_i = d; src_i = s;
        @(negedge clk);
        check(tag, res_o, model(op, hi, d, s));
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        // R1: reset state
        op_i = 3'd5; dst_i = '1; src_i = '1;
        repeat (3) @(negedge clk);
        check("R1", res_o, 64'h0);
        rst_n = 1'b1;

        // R3 boundaries: 32767, 32768, -32768, -32769
        run(3'd0, 1'b0, {32'h0000_8000, 32'h0000_7FFF}, {32'hFFFF_7FFF, 32'hFFFF_8000}, "R3");
        // R4 boundaries: 127, 128, -128, -129
        run(3'd1, 1'b0, {16'hFF7F, 16'hFF80, 16'h0080, 16'h007F}, 64'h0001_FFFF_0000_7FFF, "R4");
        // R5 boundaries: 255, 256, -1, 0
        run(3'd2, 1'b0, {16'h0000, 16'hFFFF, 16'h0100, 16'h00FF}, 64'h8000_7FFF_0001_0080, "R5");
        // R6: zero-extension of low and high bytes, R2 opcode 3
        run(3'd3, 1'b0, 64'h8877_6655_4433_2211, 64'h0, "R6");
        run(3'd3, 1'b1, 64'h8877_6655_4433_2211, 64'h0, "R6");
        run(3'd4, 1'b1, 64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_9988, "R7");
        run(3'd5, 1'b0, 64'h8877_6655_4433_2211, 64'hFFEE_DDCC_BBAA_9988, "R8");
        // R9: bits 6:3 ignored, repeated index
        run(3'd6, 1'b0, 64'h8877_6655_4433_2211, 64'h7F78_0505_4A3B_0100, "R9");
        // R10: lanes with bit 7 set cleared
        run(3'd6, 1'b0, 64'h8877_6655_4433_2211, 64'h80FF_0185_0302_8100, "R10");
        run(3'd7, 1'b1, 64'h8877_6655_4433_2211, 64'h1234, "R11");
        // R12: half select ignored for pack and shuffle
        run(3'd1, 1'b1, 64'h0001_FFFF_0000_7FFF, 64'h0042_0080_FF00_0005, "R12");
        run(3'd6, 1'b1, 64'h8877_6655_4433_2211, 64'h0706_0504_0302_0100, "R12");

        // R2 and the rest: random over every opcode and half
        for (int n = 0; n < 3000; n++) begin
            logic [2:0]  op = 3'($urandom_range(0, 7));
            logic        hi = 1'($urandom);
            logic [63:0] d  = {$urandom, $urandom};
            logic [63:0] s  = {$urandom, $urandom};
            if (n % 4 == 0) begin
                for (int j = 0; j < 4; j++) d[16*j +: 16] = 16'($signed(8'($urandom)));
            end
            run(op, hi, d, s, tag_of(op, hi));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule